// File: doc/BRIEF.md
# Sleep Timer with Wakeup Logic

A word-addressed register block holding a down-counter that runs on one of two tick-enable inputs while software keeps it running. When the count steps from 1 to 0 the block raises its interrupt. Software can force the interrupt on or request that it be dropped. Both requests stay visible in a status word until the design acts on them. A clear request cannot take effect while the running counter holds 1, because an expiry at that count always wins.

A second wake source watches a serial-wire debug clock pin. The pin passes through a two-stage synchronizer. A falling edge seen on it latches a debugger wake flag, but only when software has armed the feature and both the radio-power-down and debugger-enable inputs are high. The wake output is the OR of the interrupt and that flag. It goes to an external power controller that can bring the core back up.

The whole block runs from one clock. The slower time bases arrive as single-cycle tick enables. Read data is registered and appears one cycle after the word address is presented.

Top module: `slumber_timer`

## Requirements
- R1: After a synchronous active-high reset, every register holds zero: reads of words 0, 1 and 2 return 0, and `irq` and `wake` are low.
- R2: Word 0 (control) stores the run bit at bit 0, the fast-tick select at bit 8, the slow-tick select at bit 9 and the debugger-wake arm at bit 24. It reads back live status at bit 5 (counter bit 31), bit 6 (`lp_clk_lvl`) and bit 7 (active, equal to the run bit). Word 1 reads the same three status values at bits 5, 6 and 7. `bus_rdata` shows the word addressed on the previous clock edge.
- R3: A write to word 2 loads the counter on that edge and beats a decrement in the same cycle. Reads of word 2 return the count.
- R4: While the run bit is 1, the counter drops by one on each cycle where `fast_tick` is high with bit 8 set, or `slow_tick` is high with bit 9 set. Other ticks are ignored. With the run bit at 0 the count holds. A decrement from 0 wraps to all ones without raising the interrupt.
- R5: A decrement from 1 to 0 sets the interrupt. Its state reads at word 1 bit 0 and drives `irq`.
- R6: Writing 1 to word 1 bit 2 marks a set request. The bit reads 1 until the next edge, which sets the interrupt. Writing 0 there changes nothing.
- R7: Writing 1 to word 1 bit 1 marks a clear request. The bit reads 1 until the interrupt is cleared. The clear is held off on every cycle where the run bit is 1 and the count is 1, and also on cycles with a set request or an expiry. Writing 0 there changes nothing.
- R8: Word 1 bit 8 is the debugger wake flag. It is set by a synchronized falling edge of `swclk` only while word 0 bit 24, `radio_down` and `dbg_en` are all 1. Rising edges do nothing. Writing 1 to the bit clears it.
- R9: `wake` equals `irq` OR the debugger wake flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the block |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_word | input | ADDR_W | Word address: 0 control, 1 interrupt/wake status, 2 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the word addressed on the previous edge |
| fast_tick | input | 1 | Fast time-base tick enable |
| slow_tick | input | 1 | Low-power time-base tick enable |
| lp_clk_lvl | input | 1 | Current level of the low-power clock, reported as status |
| swclk | input | 1 | Asynchronous serial-wire debug clock pin |
| radio_down | input | 1 | High while the radio power domain is off |
| dbg_en | input | 1 | High when the debugger port is enabled for wakeup |
| irq | output | 1 | Timer interrupt state |
| wake | output | 1 | Interrupt OR debugger wake flag |

## Verification
The bench loads a count of 1 and lets it expire while a clear request is pending. A design that lets the clear through on the count-of-1 cycle would leave the interrupt low, and one that drops the request would leave it high for good. It decrements from 0 and expects a wrap to all ones with no interrupt; a wrong expiry compare would fire there. It asserts a tick on the same edge as a count load and expects the loaded value to survive; a wrong priority would leave the value one lower. It also drives rising edges and falling edges with one arming condition missing. A wrong edge polarity or a missing gate would set the debugger flag and `wake` when they must stay low.

// File: rtl/slumber_pkg.sv
package slumber_pkg;
  localparam int DATA_W = 32;

  localparam int WORD_CTRL  = 0;
  localparam int WORD_STAT  = 1;
  localparam int WORD_COUNT = 2;

  // control word fields
  localparam int C_RUN      = 0;
  localparam int C_SIGN     = 5;
  localparam int C_LPCLK    = 6;
  localparam int C_ACTIVE   = 7;
  localparam int C_SEL_FAST = 8;
  localparam int C_SEL_SLOW = 9;
  localparam int C_DBG_ARM  = 24;

  // status word fields
  localparam int S_IRQ      = 0;
  localparam int S_CLR      = 1;
  localparam int S_SET      = 2;
  localparam int S_DBG_FLAG = 8;
endpackage

// File: rtl/slumber_counter.sv
module slumber_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_one,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_one = (cnt_q == ONE);
  assign expire = tick && !ld && at_one;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (tick) cnt_q <= cnt_q - ONE;
  end

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt_q == $past(ld_val));
  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld) |=> cnt_q == $past(cnt_q) - ONE);
  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld) |=> $stable(cnt_q));
endmodule

// File: rtl/slumber_irq.sv
module slumber_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic expire,
  input  logic block,
  output logic irq_q,
  output logic set_pend,
  output logic clr_pend
);
  logic clr_go;

  assign clr_go = clr_pend && !block && !set_pend && !expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= 1'b0;
      set_pend <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      set_pend <= set_req;
      clr_pend <= clr_go ? clr_req : (clr_pend || clr_req);
      if (expire || set_pend) irq_q <= 1'b1;
      else if (clr_go)        irq_q <= 1'b0;
    end
  end

  // R5
  expire_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (expire || set_pend) |=> irq_q);
  // R6
  set_retires_chk: assert property (@(posedge clk) disable iff (rst)
    (set_pend && !set_req) |=> !set_pend);
  // R7
  clr_held_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pend && block) |=> clr_pend);
  // R7
  clr_done_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pend && !block && !set_pend && !expire) |=> !irq_q);
endmodule

// File: rtl/slumber_swd_wake.sv
module slumber_swd_wake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic swclk,
  input  logic arm,
  input  logic clr_req,
  output logic flag_q
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], swclk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q && !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)              flag_q <= 1'b0;
    else if (fall && arm) flag_q <= 1'b1;
    else if (clr_req)     flag_q <= 1'b0;
  end

  // R8
  edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (fall && arm) |=> flag_q);
  // R8
  flag_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!(fall && arm) && clr_req) |=> !flag_q);
  // R8
  no_stray_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(fall && arm)) |=> !flag_q);
endmodule

// File: rtl/slumber_timer.sv
module slumber_timer
  import slumber_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fast_tick,
  input  logic              slow_tick,
  input  logic              lp_clk_lvl,
  input  logic              swclk,
  input  logic              radio_down,
  input  logic              dbg_en,
  output logic              irq,
  output logic              wake
);
  logic run_q, sel_fast_q, sel_slow_q, dbg_arm_q;
  logic wr_ctrl, wr_stat, wr_count;
  logic tick, at_one, expire, block;
  logic set_pend, clr_pend, irq_q, flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] ctrl_rd, stat_rd, rd_next;

  assign wr_ctrl  = bus_we && (bus_word == ADDR_W'(WORD_CTRL));
  assign wr_stat  = bus_we && (bus_word == ADDR_W'(WORD_STAT));
  assign wr_count = bus_we && (bus_word == ADDR_W'(WORD_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      sel_fast_q <= 1'b0;
      sel_slow_q <= 1'b0;
      dbg_arm_q  <= 1'b0;
    end else if (wr_ctrl) begin
      run_q      <= bus_wdata[C_RUN];
      sel_fast_q <= bus_wdata[C_SEL_FAST];
      sel_slow_q <= bus_wdata[C_SEL_SLOW];
      dbg_arm_q  <= bus_wdata[C_DBG_ARM];
    end
  end

  assign tick  = run_q && ((sel_fast_q && fast_tick) || (sel_slow_q && slow_tick));
  assign block = run_q && at_one;

  slumber_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ld     (wr_count),
    .ld_val (bus_wdata[CNT_W-1:0]),
    .tick   (tick),
    .cnt_q  (cnt_q),
    .at_one (at_one),
    .expire (expire)
  );

  slumber_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_req  (wr_stat && bus_wdata[S_SET]),
    .clr_req  (wr_stat && bus_wdata[S_CLR]),
    .expire   (expire),
    .block    (block),
    .irq_q    (irq_q),
    .set_pend (set_pend),
    .clr_pend (clr_pend)
  );

  slumber_swd_wake #(.SYNC_STAGES(SYNC_STAGES)) u_swd (
    .clk     (clk),
    .rst     (rst),
    .swclk   (swclk),
    .arm     (dbg_arm_q && radio_down && dbg_en),
    .clr_req (wr_stat && bus_wdata[S_DBG_FLAG]),
    .flag_q  (flag_q)
  );

  always_comb begin
    ctrl_rd             = '0;
    ctrl_rd[C_RUN]      = run_q;
    ctrl_rd[C_SIGN]     = cnt_q[CNT_W-1];
    ctrl_rd[C_LPCLK]    = lp_clk_lvl;
    ctrl_rd[C_ACTIVE]   = run_q;
    ctrl_rd[C_SEL_FAST] = sel_fast_q;
    ctrl_rd[C_SEL_SLOW] = sel_slow_q;
    ctrl_rd[C_DBG_ARM]  = dbg_arm_q;

    stat_rd             = '0;
    stat_rd[S_IRQ]      = irq_q;
    stat_rd[S_CLR]      = clr_pend;
    stat_rd[S_SET]      = set_pend;
    stat_rd[C_SIGN]     = cnt_q[CNT_W-1];
    stat_rd[C_LPCLK]    = lp_clk_lvl;
    stat_rd[C_ACTIVE]   = run_q;
    stat_rd[S_DBG_FLAG] = flag_q;

    case (bus_word)
      ADDR_W'(WORD_CTRL):  rd_next = ctrl_rd;
      ADDR_W'(WORD_STAT):  rd_next = stat_rd;
      ADDR_W'(WORD_COUNT): rd_next = DATA_W'(cnt_q);
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign irq  = irq_q;
  assign wake = irq_q || flag_q;

  // R2
  rdata_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_word == ADDR_W'(WORD_COUNT) && !wr_count) |=> bus_rdata == DATA_W'($past(cnt_q)));
  // R4
  stopped_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_count) |=> $stable(cnt_q));
endmodule

// File: tb/slumber_timer_test.sv
module slumber_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fast_tick = 1'b0, slow_tick = 1'b0, lp_clk_lvl = 1'b0;
  logic        swclk = 1'b0, radio_down = 1'b0, dbg_en = 1'b0;
  logic        irq, wake;

  int          n_vec = 0;
  int          n_bad = 0;
  longint      cyc = 0;
  bit          done = 1'b0;

  int          q_which[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  longint      q_due[$];

  slumber_timer uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fast_tick(fast_tick), .slow_tick(slow_tick), .lp_clk_lvl(lp_clk_lvl),
    .swclk(swclk), .radio_down(radio_down), .dbg_en(dbg_en),
    .irq(irq), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expectations as they fall due and compare
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      int          w;
      logic [31:0] e, a;
      string       t;
      w = q_which.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      a = (w == 0) ? bus_rdata : (w == 1) ? {31'b0, irq} : {31'b0, wake};
      n_vec++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got 0x%08h expected 0x%08h", t, a, e);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] w, input logic [31:0] d);
    bus_we = 1'b1; bus_word = w; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic push(input int which, input logic [31:0] e, input string t);
    q_which.push_back(which);
    q_exp.push_back(e);
    q_tag.push_back(t);
    q_due.push_back(cyc + 1);
  endtask

  task automatic rd(input logic [1:0] w, input logic [31:0] e, input string t);
    bus_word = w;
    push(0, e, t);
    step();
  endtask

  task automatic port(input int which, input logic e, input string t);
    push(which, {31'b0, e}, t);
    step();
  endtask

  task automatic pulse_fast();
    fast_tick = 1'b1; step(); fast_tick = 1'b0;
  endtask

  task automatic pulse_slow();
    slow_tick = 1'b1; step(); slow_tick = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, 32'h0, "R1 control after reset");
    rd(2'd1, 32'h0, "R1 status after reset");
    rd(2'd2, 32'h0, "R1 count after reset");
    port(1, 1'b0, "R1 irq after reset");
    port(2, 1'b0, "R1 wake after reset");

    // R2 control fields and low-power clock status
    wr(2'd0, 32'h0100_0300);
    rd(2'd0, 32'h0100_0300, "R2 control readback");
    lp_clk_lvl = 1'b1;
    rd(2'd0, 32'h0100_0340, "R2 lp clock level in control");
    rd(2'd1, 32'h0000_0040, "R2 lp clock level in status");
    lp_clk_lvl = 1'b0;

    // R3 load, R2 active bit
    wr(2'd2, 32'd5);
    rd(2'd2, 32'd5, "R3 count load");
    wr(2'd0, 32'h0000_0101);
    rd(2'd0, 32'h0000_0181, "R2 active bit with run set");

    // R4 tick selection and run gating
    pulse_fast();
    rd(2'd2, 32'd4, "R4 fast tick decrements");
    pulse_slow();
    rd(2'd2, 32'd4, "R4 unselected slow tick ignored");
    wr(2'd0, 32'h0000_0201);
    pulse_slow();
    rd(2'd2, 32'd3, "R4 slow tick decrements");
    wr(2'd0, 32'h0000_0200);
    pulse_slow();
    rd(2'd2, 32'd3, "R4 stopped counter holds");

    // R4 wrap from zero, no interrupt
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h0000_0101);
    pulse_fast();
    rd(2'd2, 32'hFFFF_FFFF, "R4 wrap to all ones");
    rd(2'd0, 32'h0000_01A1, "R2 sign bit after wrap");
    rd(2'd1, 32'h0000_00A0, "R4 wrap raises no interrupt");

    // R3 load beats a same-cycle tick
    bus_we = 1'b1; bus_word = 2'd2; bus_wdata = 32'h10; fast_tick = 1'b1;
    step();
    bus_we = 1'b0; fast_tick = 1'b0;
    rd(2'd2, 32'h10, "R3 load wins over tick");

    // R5 expiry
    wr(2'd2, 32'd2);
    pulse_fast();
    pulse_fast();
    rd(2'd1, 32'h0000_0081, "R5 expiry sets interrupt");
    port(1, 1'b1, "R5 irq port after expiry");
    port(2, 1'b1, "R9 wake follows irq");

    // R7 clear request with pending readback
    wr(2'd1, 32'h0000_0002);
    rd(2'd1, 32'h0000_0083, "R7 clear pending visible");
    rd(2'd1, 32'h0000_0080, "R7 clear took effect");
    port(2, 1'b0, "R9 wake low after clear");

    // R6 set request
    wr(2'd2, 32'd1);
    wr(2'd1, 32'h0000_0004);
    rd(2'd1, 32'h0000_0084, "R6 set pending visible");
    rd(2'd1, 32'h0000_0081, "R6 set took effect");

    // R7 clear held at count of one, expiry wins
    wr(2'd1, 32'h0000_0002);
    rd(2'd1, 32'h0000_0083, "R7 clear held at count one");
    rd(2'd1, 32'h0000_0083, "R7 clear still held");
    pulse_fast();
    rd(2'd1, 32'h0000_0083, "R7 expiry beat pending clear");
    rd(2'd1, 32'h0000_0080, "R7 clear released after expiry");

    // R6 R7 writing zeros has no effect
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, 32'h0000_0080, "R6 zero write sets nothing");
    wr(2'd1, 32'h0000_0004);
    step();
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, 32'h0000_0081, "R7 zero write clears nothing");
    wr(2'd1, 32'h0000_0002);
    wait_n(2);
    rd(2'd1, 32'h0000_0080, "R7 final clear");

    // R8 debugger wake flag
    wr(2'd0, 32'h0100_0000);
    radio_down = 1'b1; dbg_en = 1'b1; swclk = 1'b1;
    wait_n(4);
    rd(2'd1, 32'h0000_0000, "R8 rising edge sets nothing");
    swclk = 1'b0;
    wait_n(4);
    rd(2'd1, 32'h0000_0100, "R8 falling edge sets flag");
    port(1, 1'b0, "R9 irq stays low");
    port(2, 1'b1, "R9 wake from debugger flag");
    wr(2'd1, 32'h0000_0100);
    rd(2'd1, 32'h0000_0000, "R8 write one clears flag");
    port(2, 1'b0, "R9 wake low after flag clear");

    dbg_en = 1'b0; swclk = 1'b1; wait_n(4); swclk = 1'b0; wait_n(4);
    rd(2'd1, 32'h0000_0000, "R8 debugger disable gates edge");
    dbg_en = 1'b1; radio_down = 1'b0;
    swclk = 1'b1; wait_n(4); swclk = 1'b0; wait_n(4);
    rd(2'd1, 32'h0000_0000, "R8 radio up gates edge");
    radio_down = 1'b1;
    wr(2'd0, 32'h0000_0000);
    swclk = 1'b1; wait_n(4); swclk = 1'b0; wait_n(4);
    rd(2'd1, 32'h0000_0000, "R8 unarmed gates edge");
    port(2, 1'b0, "R9 wake low when unarmed");

    wait_n(3);
    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < WATCHDOG) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", wd);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule